// File: doc/BRIEF.md
# SPI Target Busy-Flow Signaler

This block sits on the peripheral side of a SPI link and tells the host, using only the target-to-host data line, whether the target can take or supply data. There is no separate ready pin. While the target is not ready, every word it clocks out is all zeros. The host keeps clocking and ignores those words. Once the target is ready, it sends one word made only of ones. The word after that is the first real data word. The same scheme is used whether the host is writing or reading.

The word length is chosen per transfer by a configuration input: 16 or 32 bits. The transfer direction is chosen the same way. Both are captured only while chip select is inactive. SCLK, chip select and host-to-target data pass through a small synchronizer into the system clock domain. Bits travel most-significant first, and the host samples on rising SCLK (SPI mode 0). On the local side, a valid/ready pair hands out each received write word. A second valid/ready pair takes in the words to be read.

Top module: `spi_busy_flow`

## Requirements
- R1: While the target is busy, every bit it drives on `poci` during a word is 0.
- R2: Readiness is sampled only when chip select becomes active and at each word boundary. Readiness means `wr_ready` for writes and `rd_valid` for reads. If it is seen, the next word on `poci` is all ones: the marker word.
- R3: In write direction the first data word is the one right after the marker word. Each data word appears on `wr_data` with its first-clocked `pico` bit as bit W-1. Words are zero-extended to 32 bits.
- R4: `pico` bits clocked during busy and marker words are discarded. Exactly one `wr_valid` handshake occurs per complete write data word.
- R5: In read direction, data words start right after the marker word. Each is the low W bits of `rd_data`, sent bit W-1 first. A `rd_ready` pulse one clock wide marks the end of each data word that was sent.
- R6: If `rd_valid` is low at a read data-word boundary, that word is sent as zeros and nothing is consumed. The next word carries the pending value.
- R7: `cfg_wide` (1 = 32-bit words, 0 = 16-bit words) is captured only while `cs_n` is high. A change during a transfer has no effect until the next transfer.
- R8: Raising `cs_n` in the middle of a word abandons that word. A partial write word is never delivered, a partial read word is not consumed, and the next transfer starts again with busy evaluation at bit 0.
- R9: `cfg_rd` (1 = read, 0 = write) is captured the same way as `cfg_wide`. In write direction, `poci` is 1 during data words.
- R10: After reset, `poci`, `wr_valid` and `rd_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from the host, mode 0 |
| cs_n | input | 1 | Chip select, active low |
| pico | input | 1 | Host-to-target serial data |
| poci | output | 1 | Target-to-host serial data and flow signal |
| cfg_wide | input | 1 | Word length select: 1 = 32 bits, 0 = 16 bits |
| cfg_rd | input | 1 | Direction select: 1 = read, 0 = write |
| wr_valid | output | 1 | Received write word available |
| wr_ready | input | 1 | Local sink can take a write word |
| wr_data | output | 32 | Received write word, zero-extended |
| rd_valid | input | 1 | Local source offers a read word |
| rd_ready | output | 1 | Read word consumed |
| rd_data | input | 32 | Read word to send |

## Verification
A wrong phase state shows up on `poci` within one word time. A busy word that carries ones, or a marker word that goes missing, makes every later data word land one word off, both in the words the host collects and in the `wr_data` sequence. A bit counter that drifts or fails to clear on chip-select release changes the word length the host sees. The bench catches this on the very next word, because every word is compared whole. Handshake faults show up as extra or missing `wr_valid` or `rd_ready` events once the transfer closes.

// File: rtl/spi_busy_pkg.sv
package spi_busy_pkg;
  // Per-word phase of the flow signaler
  typedef enum logic [1:0] {
    PH_BUSY = 2'd0,
    PH_MARK = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_busy_sync.sv
module spi_busy_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_busy_ctrl.sv
module spi_busy_ctrl
  import spi_busy_pkg::*;
#(
  parameter int NARROW_BITS = 16,
  parameter int WIDE_BITS   = 32,
  localparam int CW = $clog2(WIDE_BITS)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   cs_act,
  input  logic   sclk_s,
  input  logic   cfg_wide,
  input  logic   cfg_rd,
  input  logic   ready_in,
  output logic   wide_q,
  output logic   rd_q,
  output phase_t phase,
  output phase_t phase_nxt,
  output logic   sclk_rise,
  output logic   shift,
  output logic   word_end,
  output logic   load
);
  logic          sclk_prev;
  logic          cs_prev;
  logic          cs_start;
  logic          sclk_fall;
  logic          bnd1;
  logic [CW-1:0] bitcnt;
  logic [CW-1:0] last_idx;
  logic          at_last;

  assign sclk_rise = cs_act & sclk_s & ~sclk_prev;
  assign sclk_fall = cs_act & ~sclk_s & sclk_prev;
  assign cs_start  = cs_act & ~cs_prev;
  assign last_idx  = wide_q ? CW'(WIDE_BITS - 1) : CW'(NARROW_BITS - 1);
  assign at_last   = (bitcnt == last_idx);
  // A falling edge right after a word boundary keeps the freshly loaded bit
  assign shift     = sclk_fall & (bitcnt != '0);

  always_comb begin
    unique case (phase)
      PH_BUSY: phase_nxt = ready_in ? PH_MARK : PH_BUSY;
      PH_MARK: phase_nxt = PH_DATA;
      default: phase_nxt = PH_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      cs_prev   <= cs_act;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt   <= '0;
      phase    <= PH_BUSY;
      word_end <= 1'b0;
      bnd1     <= 1'b0;
      load     <= 1'b0;
      wide_q   <= 1'b0;
      rd_q     <= 1'b0;
    end else if (!cs_act) begin
      bitcnt   <= '0;
      phase    <= PH_BUSY;
      word_end <= 1'b0;
      bnd1     <= 1'b0;
      load     <= 1'b0;
      wide_q   <= cfg_wide;
      rd_q     <= cfg_rd;
    end else begin
      word_end <= sclk_rise & at_last;
      if (sclk_rise) bitcnt <= at_last ? '0 : bitcnt + CW'(1);
      // Two idle cycles between word end and load leave room for the read handshake
      bnd1 <= word_end | cs_start;
      load <= bnd1;
      if (load) phase <= phase_nxt;
    end
  end
endmodule

// File: rtl/spi_busy_shift.sv
module spi_busy_shift
  import spi_busy_pkg::*;
#(
  parameter int NARROW_BITS = 16,
  parameter int WIDE_BITS   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_act,
  input  logic                 wide_q,
  input  logic                 rd_q,
  input  phase_t               phase,
  input  phase_t               phase_nxt,
  input  logic                 sclk_rise,
  input  logic                 shift,
  input  logic                 word_end,
  input  logic                 load,
  input  logic                 pico_s,
  output logic                 poci,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [WIDE_BITS-1:0] wr_data,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [WIDE_BITS-1:0] rd_data
);
  localparam logic [WIDE_BITS-1:0] NARROW_MASK =
    {{(WIDE_BITS - NARROW_BITS){1'b0}}, {NARROW_BITS{1'b1}}};

  logic [WIDE_BITS-1:0] tx;
  logic [WIDE_BITS-1:0] rx;
  logic                 owned;

  assign poci = cs_act & (wide_q ? tx[WIDE_BITS-1] : tx[NARROW_BITS-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx       <= '0;
      rx       <= '0;
      owned    <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      rd_ready <= 1'b0;
    end else begin
      rd_ready <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (!cs_act) begin
        tx    <= '0;
        owned <= 1'b0;
      end else begin
        if (sclk_rise) rx <= {rx[WIDE_BITS-2:0], pico_s};
        if (word_end && phase == PH_DATA) begin
          if (rd_q) begin
            rd_ready <= owned;
          end else begin
            wr_data  <= wide_q ? rx : (rx & NARROW_MASK);
            wr_valid <= 1'b1;
          end
        end
        if (load) begin
          unique case (phase_nxt)
            PH_BUSY: begin
              tx    <= '0;
              owned <= 1'b0;
            end
            PH_MARK: begin
              tx    <= '1;
              owned <= 1'b0;
            end
            default: begin
              if (rd_q) begin
                tx    <= rd_valid ? rd_data : '0;
                owned <= rd_valid;
              end else begin
                tx    <= '1;
                owned <= 1'b0;
              end
            end
          endcase
        end else if (shift) begin
          tx <= {tx[WIDE_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_busy_flow.sv
module spi_busy_flow
  import spi_busy_pkg::*;
#(
  parameter int NARROW_BITS = 16,
  parameter int WIDE_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 pico,
  output logic                 poci,
  input  logic                 cfg_wide,
  input  logic                 cfg_rd,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [WIDE_BITS-1:0] wr_data,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [WIDE_BITS-1:0] rd_data
);
  logic [2:0] pins_s;
  logic       sclk_s;
  logic       cs_act;
  logic       pico_s;
  logic       wide_q;
  logic       rd_q;
  phase_t     phase;
  phase_t     phase_nxt;
  logic       sclk_rise;
  logic       shift;
  logic       word_end;
  logic       load;
  logic       ready_in;

  spi_busy_sync #(.STAGES(SYNC_STAGES), .LINES(3)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({pico, ~cs_n, sclk}),
    .dout (pins_s)
  );

  assign sclk_s   = pins_s[0];
  assign cs_act   = pins_s[1];
  assign pico_s   = pins_s[2];
  assign ready_in = rd_q ? rd_valid : wr_ready;

  spi_busy_ctrl #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .sclk_s    (sclk_s),
    .cfg_wide  (cfg_wide),
    .cfg_rd    (cfg_rd),
    .ready_in  (ready_in),
    .wide_q    (wide_q),
    .rd_q      (rd_q),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .sclk_rise (sclk_rise),
    .shift     (shift),
    .word_end  (word_end),
    .load      (load)
  );

  spi_busy_shift #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .wide_q    (wide_q),
    .rd_q      (rd_q),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .sclk_rise (sclk_rise),
    .shift     (shift),
    .word_end  (word_end),
    .load      (load),
    .pico_s    (pico_s),
    .poci      (poci),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/spi_busy_flow_chk.sv
module spi_busy_flow_chk
  import spi_busy_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   cs_act,
  input phase_t phase,
  input logic   poci,
  input logic   wide_q,
  input logic   rd_q,
  input logic   wr_valid,
  input logic   rd_ready
);
  // R1: busy words carry only zeros
  p_busy_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (cs_act && phase == PH_BUSY) |-> !poci);

  // R2: the marker word carries only ones
  p_mark_ones_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_act && phase == PH_MARK) |-> poci);

  // R2: a marker word is entered only from busy
  p_mark_from_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MARK && $past(phase) != PH_MARK) |-> $past(phase) == PH_BUSY);

  // R4: write words are delivered only out of the data phase of a write transfer
  p_wr_only_data_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> ($past(phase) == PH_DATA && !rd_q));

  // R5: consume strobe lasts a single clock
  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> !rd_ready);

  // R7 and R9: configuration is frozen while selected
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cs_act && $past(cs_act)) |-> ($stable(wide_q) && $stable(rd_q)));

  // R8: release of chip select returns to busy evaluation
  p_cs_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> phase == PH_BUSY);

  // R9: consume strobe only in read direction
  p_rd_dir_r9: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> rd_q);
endmodule

bind spi_busy_flow spi_busy_flow_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_act   (cs_act),
  .phase    (phase),
  .poci     (poci),
  .wide_q   (wide_q),
  .rd_q     (rd_q),
  .wr_valid (wr_valid),
  .rd_ready (rd_ready)
);

// File: tb/test_spi_busy_flow.sv
`timescale 1ns/1ps
module test_spi_busy_flow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        pico = 1'b0;
  logic        poci;
  logic        cfg_wide = 1'b0;
  logic        cfg_rd = 1'b0;
  logic        wr_valid;
  logic        wr_ready;
  logic [31:0] wr_data;
  logic        rd_valid;
  logic        rd_ready;
  logic [31:0] rd_data;

  logic        rdy = 1'b0;
  logic        src_en = 1'b1;
  logic        drop_req = 1'b0;
  logic        rd_mode = 1'b0;
  int          rd_idx = 0;
  int          wr_cnt = 0;
  logic [31:0] wr_got [0:15];
  int          nchk = 0;
  int          nerr = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] wpat(input int i);
    return 32'h8F1B_3C4D ^ (32'h0107_0B0D * (i + 1));
  endfunction

  function automatic logic [31:0] rpat(input int i);
    return (32'h1234_5679 * (i + 3)) ^ 32'h5A00_00A5;
  endfunction

  assign wr_ready = rdy;
  assign rd_valid = rdy & src_en & rd_mode;
  assign rd_data  = rpat(rd_idx);

  spi_busy_flow i_spi_busy_flow (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .pico     (pico),
    .poci     (poci),
    .cfg_wide (cfg_wide),
    .cfg_rd   (cfg_rd),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data)
  );

  // Local sink and source models, sampled mid-cycle
  always @(negedge clk) begin
    if (wr_valid && wr_ready) begin
      wr_got[wr_cnt[3:0]] = wr_data;
      wr_cnt = wr_cnt + 1;
    end
    if (rd_valid && rd_ready) begin
      rd_idx = rd_idx + 1;
      if (drop_req) begin
        src_en   = 1'b0;
        drop_req = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  // One transfer: k busy words, a marker word, nd data words, optional partial word
  task automatic xfer(input bit wide, input bit rd, input int k, input int nd,
                      input int partial, input bit flip, input int drop_w);
    int          wbits;
    int          total;
    int          base;
    int          bad;
    logic [31:0] mask;
    wbits = wide ? 32 : 16;
    mask  = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    total = k + 1 + nd;
    bad   = 0;
    cfg_wide = wide;
    cfg_rd   = rd;
    rd_mode  = rd;
    rdy      = (k == 0);
    src_en   = 1'b1;
    wr_cnt   = 0;
    base     = rd_idx;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (16) @(negedge clk);
    if (flip) cfg_wide = ~wide;
    for (int w = 0; w <= total; w++) begin
      int          nb;
      logic [31:0] txw;
      logic [31:0] got;
      logic [31:0] exp;
      string       tag;
      nb  = (w == total) ? partial : wbits;
      txw = (w > k) ? wpat(w - k - 1) : (32'hA5C3_96E1 ^ w);
      got = '0;
      for (int b = 0; b < nb; b++) begin
        pico = txw[wbits - 1 - b];
        repeat (8) @(negedge clk);
        got = {got[30:0], poci};
        sclk = 1'b1;
        if (b == 0) begin
          if (w + 1 >= k) rdy = 1'b1;
          if (drop_w >= 1 && w == k + drop_w) drop_req = 1'b1;
          if (drop_w >= 1 && w == k + 1 + drop_w) src_en = 1'b1;
        end
        repeat (8) @(negedge clk);
        sclk = 1'b0;
      end
      if (w < total) begin
        if (w < k) begin
          exp = 32'h0;
          tag = "R1 busy word";
        end else if (w == k) begin
          exp = mask;
          tag = "R2 marker word";
        end else if (!rd) begin
          exp = mask;
          tag = "R9 write data poci";
        end else begin
          int j;
          j = w - k - 1;
          if (drop_w >= 1 && j == drop_w) begin
            exp = 32'h0;
            tag = "R6 underrun word";
          end else if (drop_w >= 1 && j > drop_w) begin
            exp = rpat(base + j - 1) & mask;
            tag = "R6 word after underrun";
          end else begin
            exp = rpat(base + j) & mask;
            tag = "R5 read data word";
          end
        end
        if (got !== exp) bad = bad + 1;
        chk(tag, got, exp);
      end
    end
    repeat (8) @(negedge clk);
    cs_n     = 1'b1;
    cfg_wide = wide;
    repeat (16) @(negedge clk);
    rdy = 1'b0;
    if (!rd) begin
      chk(partial > 0 ? "R8 write count after abort" : "R4 write word count", wr_cnt, nd);
      for (int j = 0; j < nd; j++) chk("R3 write data word", wr_got[j], wpat(j) & mask);
    end else begin
      chk(partial > 0 ? "R8 read consume after abort" : "R5 read consume count",
          rd_idx - base, (drop_w >= 1) ? nd - 1 : nd);
    end
    if (flip) chk("R7 width held during transfer", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk = nchk + 1;
    nerr = nerr + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 reset poci", poci, 0);
    chk("R10 reset wr_valid", wr_valid, 0);
    chk("R10 reset rd_ready", rd_ready, 0);
    for (int wd = 0; wd < 2; wd++)
      for (int dr = 0; dr < 2; dr++)
        for (int k = 0; k < 4; k++)
          xfer(wd[0], dr[0], k, 3, 0, 1'b0, -1);
    xfer(1'b0, 1'b0, 1, 2, 0, 1'b1, -1);
    xfer(1'b1, 1'b1, 0, 2, 0, 1'b1, -1);
    xfer(1'b0, 1'b1, 1, 4, 0, 1'b0, 1);
    xfer(1'b1, 1'b1, 0, 3, 0, 1'b0, 2);
    xfer(1'b0, 1'b0, 1, 2, 7, 1'b0, -1);
    xfer(1'b0, 1'b0, 2, 2, 0, 1'b0, -1);
    xfer(1'b1, 1'b1, 0, 1, 9, 1'b0, -1);
    xfer(1'b1, 1'b1, 1, 2, 0, 1'b0, -1);
    finish_run();
  end
endmodule